// File: doc/BRIEF.md
# Transmit Descriptor Suspend Controller

This block walks a DMA transmit engine around a ring of transmit descriptors. For each ring slot it requests the descriptor, looks at the ownership flag that comes back, and either starts a transmission or stops in a suspended state. When the data mover reports the end of a transmission, the block closes the descriptor with a one-cycle pulse and an error bit, then moves to the next slot. The ring length is a parameter, and the slot index wraps to zero after the last entry.

There are two ways into suspension. The first is a fetch that returns a descriptor still owned by the host. The second is a transmission that ends in a local error. Either one sets two sticky flags, an abnormal summary flag and a transmit interrupt flag, and the host clears each of them with a one-cycle clear pulse. In suspension the slot index stays at the entry after the last closed descriptor. The engine does not look at the ring again until the host sends a poll-demand pulse, and that pulse fetches the retained slot again.

The state machine has five states. IDLE waits for the start level. FETCH holds the fetch request until the response arrives. XMIT waits for the done or error strobe. CLOSE issues the close pulse and advances the slot. SUSP waits for a poll demand. The transitions are:
- IDLE→FETCH on start.
- FETCH→XMIT on a response that is device-owned.
- FETCH→SUSP on a response that is host-owned.
- XMIT→CLOSE on done or error.
- CLOSE→FETCH when there was no error and start is high.
- CLOSE→IDLE when there was no error and start is low.
- CLOSE→SUSP after an error.
- SUSP→FETCH on poll demand.

Top module: `txd_suspend_ctrl`

## Requirements
- R1: After reset the slot index is 0, both flags are 0, and neither a fetch request nor a close pulse is active.
- R2: While start is high, a fetch response with the ownership bit (descriptor word 0 bit 31, carried on fetch_own_i) equal to 1 starts a transmission. The done strobe then closes that slot with close_err_o = 0, and the next slot is fetched without any poll demand.
- R3: A fetch response with the ownership bit equal to 0 (host-owned) produces no close. The block enters suspension, and both flags read 1 from the next cycle on.
- R4: An error strobe during a transmission closes the slot with close_err_o = 1. The block then enters suspension with both flags set.
- R5: The slot index changes only on a close. It stays unchanged on a host-owned suspension. After an error suspension it points at the entry after the closed one.
- R6: A close of slot RING_LEN-1 moves the index to 0. A close of any other slot moves it up by one.
- R7: While suspended, no fetch is requested until a poll-demand pulse arrives.
- R8: A poll demand in suspension fetches the retained slot again. If the host still owns that slot, the block suspends again and sets both flags again.
- R9: Both flags are sticky. clr_ais_i clears the summary flag and clr_ti_i clears the interrupt flag. A suspension event in the same cycle as a clear wins, and the flag stays 1.
- R10: While start is low in IDLE, no fetch is requested, and poll-demand pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Run level for the transmit engine |
| poll_i | input | 1 | Transmit poll-demand pulse |
| fetch_req_o | output | 1 | Descriptor fetch request for slot idx_o |
| fetch_vld_i | input | 1 | Fetch response valid |
| fetch_own_i | input | 1 | Ownership bit of the fetched descriptor (1 = device) |
| tx_start_o | output | 1 | Start transmission of the fetched descriptor |
| tx_done_i | input | 1 | Transmission finished without error |
| tx_err_i | input | 1 | Transmission aborted by a local error |
| close_o | output | 1 | Close pulse for slot idx_o |
| close_err_o | output | 1 | Error status bit written with the close |
| idx_o | output | IDX_W | Current descriptor slot index |
| ais_o | output | 1 | Sticky abnormal summary flag |
| ti_o | output | 1 | Sticky transmit interrupt flag |
| clr_ais_i | input | 1 | Clear pulse for ais_o |
| clr_ti_i | input | 1 | Clear pulse for ti_o |

## Verification
The bench builds the block with RING_LEN = 4, so that a full trip around the ring and the wrap from slot 3 to slot 0 occur after only four transmissions. With a ring that short, the bench can drive several cases to their ends in a few hundred cycles:
- an error suspension that leaves the index in the middle of the ring;
- a host-owned suspension at slot 0 right after the wrap;
- a repeated poll against a slot the host still owns.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XMIT,
        ST_CLOSE,
        ST_SUSP
    } txd_state_e;

    localparam int unsigned FLAG_AIS = 0;
    localparam int unsigned FLAG_TI  = 1;
    localparam int unsigned N_FLAGS  = 2;

endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
    parameter int unsigned RING_LEN = 8,
    parameter int unsigned IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (adv_i) begin
            if (idx_q == LAST_IDX) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/txd_sticky_flag.sv
module txd_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // A set in the same cycle as a clear takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/txd_fsm.sv
module txd_fsm
    import txd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic poll_i,
    input  logic fetch_vld_i,
    input  logic fetch_own_i,
    input  logic tx_done_i,
    input  logic tx_err_i,
    output logic fetch_req_o,
    output logic tx_start_o,
    output logic close_o,
    output logic close_err_o,
    output logic adv_o,
    output logic susp_set_o,
    output logic susp_o
);

    txd_state_e state_q;
    txd_state_e state_d;
    logic       err_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Error status captured at the end of a transmission
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (state_q == ST_XMIT && (tx_done_i || tx_err_i)) begin
            err_q <= tx_err_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (fetch_vld_i) state_d = fetch_own_i ? ST_XMIT : ST_SUSP;
            end
            ST_XMIT: begin
                if (tx_done_i || tx_err_i) state_d = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (err_q)        state_d = ST_SUSP;
                else if (start_i) state_d = ST_FETCH;
                else              state_d = ST_IDLE;
            end
            ST_SUSP: begin
                if (poll_i) state_d = ST_FETCH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fetch_req_o = 1'b0;
        tx_start_o  = 1'b0;
        close_o     = 1'b0;
        close_err_o = 1'b0;
        adv_o       = 1'b0;
        susp_set_o  = 1'b0;
        susp_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                fetch_req_o = 1'b1;
                tx_start_o  = fetch_vld_i && fetch_own_i;
                susp_set_o  = fetch_vld_i && !fetch_own_i;
            end
            ST_XMIT: ;
            ST_CLOSE: begin
                close_o     = 1'b1;
                close_err_o = err_q;
                adv_o       = 1'b1;
                susp_set_o  = err_q;
            end
            ST_SUSP: begin
                susp_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/txd_suspend_ctrl.sv
module txd_suspend_ctrl
    import txd_pkg::*;
#(
    parameter  int unsigned RING_LEN = 8,
    localparam int unsigned IDX_W    = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             poll_i,
    output logic             fetch_req_o,
    input  logic             fetch_vld_i,
    input  logic             fetch_own_i,
    output logic             tx_start_o,
    input  logic             tx_done_i,
    input  logic             tx_err_i,
    output logic             close_o,
    output logic             close_err_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             ais_o,
    output logic             ti_o,
    input  logic             clr_ais_i,
    input  logic             clr_ti_i
);

    logic               adv_w;
    logic               susp_set_w;
    logic               susp_w;
    logic [N_FLAGS-1:0] clr_vec;
    logic [N_FLAGS-1:0] flag_vec;

    txd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .poll_i      (poll_i),
        .fetch_vld_i (fetch_vld_i),
        .fetch_own_i (fetch_own_i),
        .tx_done_i   (tx_done_i),
        .tx_err_i    (tx_err_i),
        .fetch_req_o (fetch_req_o),
        .tx_start_o  (tx_start_o),
        .close_o     (close_o),
        .close_err_o (close_err_o),
        .adv_o       (adv_w),
        .susp_set_o  (susp_set_w),
        .susp_o      (susp_w)
    );

    txd_ring_ptr #(
        .RING_LEN (RING_LEN),
        .IDX_W    (IDX_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (adv_w),
        .idx_o (idx_o)
    );

    assign clr_vec[FLAG_AIS] = clr_ais_i;
    assign clr_vec[FLAG_TI]  = clr_ti_i;

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        txd_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (susp_set_w),
            .clr_i  (clr_vec[g]),
            .flag_o (flag_vec[g])
        );
    end

    assign ais_o = flag_vec[FLAG_AIS];
    assign ti_o  = flag_vec[FLAG_TI];

endmodule

// File: rtl/txd_suspend_chk.sv
module txd_suspend_chk #(
    parameter int unsigned RING_LEN = 8,
    parameter int unsigned IDX_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             poll_i,
    input logic             fetch_req_o,
    input logic             fetch_vld_i,
    input logic             fetch_own_i,
    input logic             close_o,
    input logic             close_err_o,
    input logic [IDX_W-1:0] idx_o,
    input logic             ais_o,
    input logic             ti_o,
    input logic             clr_ais_i,
    input logic             clr_ti_i,
    input logic             susp_w
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);

    logic host_hit;
    logic err_close;
    assign host_hit  = fetch_req_o && fetch_vld_i && !fetch_own_i;
    assign err_close = close_o && close_err_o;

    a_r3_host_owned_suspends: assert property (@(posedge clk) disable iff (!rst_n)
        host_hit |=> susp_w && ais_o && ti_o && !close_o);

    a_r4_abort_suspends: assert property (@(posedge clk) disable iff (!rst_n)
        err_close |=> susp_w && ais_o && ti_o);

    a_r5_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
        !close_o |=> $stable(idx_o));

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        close_o && idx_o == LAST_IDX |=> idx_o == '0);

    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        close_o && idx_o != LAST_IDX |=> idx_o == $past(idx_o) + 1'b1);

    a_r7_no_autopoll: assert property (@(posedge clk) disable iff (!rst_n)
        susp_w && !poll_i |=> susp_w && !fetch_req_o);

    a_r8_poll_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        susp_w && poll_i |=> fetch_req_o && $stable(idx_o));

    a_r9_ais_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ais_o && !clr_ais_i |=> ais_o);

    a_r9_ti_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ti_o && !clr_ti_i |=> ti_o);

    a_r9_ais_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ais_i && !host_hit && !err_close |=> !ais_o);

    a_r9_ti_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ti_i && !host_hit && !err_close |=> !ti_o);

endmodule

bind txd_suspend_ctrl txd_suspend_chk #(
    .RING_LEN (RING_LEN),
    .IDX_W    (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_i      (poll_i),
    .fetch_req_o (fetch_req_o),
    .fetch_vld_i (fetch_vld_i),
    .fetch_own_i (fetch_own_i),
    .close_o     (close_o),
    .close_err_o (close_err_o),
    .idx_o       (idx_o),
    .ais_o       (ais_o),
    .ti_o        (ti_o),
    .clr_ais_i   (clr_ais_i),
    .clr_ti_i    (clr_ti_i),
    .susp_w      (susp_w)
);

// File: tb/txd_suspend_ctrl_bench.sv
module txd_suspend_ctrl_bench;

    localparam int L     = 4;
    localparam int IW    = 2;
    localparam int TX_LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          poll_i = 1'b0;
    logic          fetch_req_o;
    logic          fetch_vld_i = 1'b0;
    logic          fetch_own_i = 1'b0;
    logic          tx_start_o;
    logic          tx_done_i = 1'b0;
    logic          tx_err_i = 1'b0;
    logic          close_o;
    logic          close_err_o;
    logic [IW-1:0] idx_o;
    logic          ais_o;
    logic          ti_o;
    logic          clr_ais_i = 1'b0;
    logic          clr_ti_i = 1'b0;

    always #5 clk = ~clk;

    txd_suspend_ctrl #(.RING_LEN(L)) u_txd_suspend_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .poll_i      (poll_i),
        .fetch_req_o (fetch_req_o),
        .fetch_vld_i (fetch_vld_i),
        .fetch_own_i (fetch_own_i),
        .tx_start_o  (tx_start_o),
        .tx_done_i   (tx_done_i),
        .tx_err_i    (tx_err_i),
        .close_o     (close_o),
        .close_err_o (close_err_o),
        .idx_o       (idx_o),
        .ais_o       (ais_o),
        .ti_o        (ti_o),
        .clr_ais_i   (clr_ais_i),
        .clr_ti_i    (clr_ti_i)
    );

    // Host-side ring model: a slot is device-owned while give_cnt differs from used_cnt.
    int give_cnt [L];
    int used_cnt [L];
    bit err_mem  [L];

    // Environment counters (written only by the env process)
    int env_checks = 0;
    int env_errs   = 0;
    int n_closes   = 0;
    // Sequence counters (written only by the main sequence)
    int seq_checks = 0;
    int seq_errs   = 0;

    logic [IW:0] sb_q [$];
    int          tx_cnt = 0;
    int          tx_idx = 0;
    bit          idx_chk_pend = 1'b0;
    int          idx_exp = 0;

    initial begin
        for (int i = 0; i < L; i++) begin
            used_cnt[i] = 0;
        end
    end

    // Driver side of the scoreboard: fetch responder and data-mover model push expected closes.
    // Monitor side: pops and compares on every close pulse.
    always @(negedge clk) begin
        fetch_vld_i <= 1'b0;
        tx_done_i   <= 1'b0;
        tx_err_i    <= 1'b0;
        if (rst_n) begin
            if (idx_chk_pend) begin
                env_checks++;
                if (int'(idx_o) != idx_exp) begin
                    env_errs++;
                    $display("FAIL R6 index after close: actual %0d expected %0d", idx_o, idx_exp);
                end
                idx_chk_pend = 1'b0;
            end
            if (close_o) begin
                env_checks++;
                if (sb_q.size() == 0) begin
                    env_errs++;
                    $display("FAIL R2 unexpected close: actual idx %0d err %0b expected none", idx_o, close_err_o);
                end else begin
                    logic [IW:0] exp_item;
                    exp_item = sb_q.pop_front();
                    if ({close_err_o, idx_o} != exp_item) begin
                        env_errs++;
                        $display("FAIL R2 R4 close: actual err %0b idx %0d expected err %0b idx %0d",
                                 close_err_o, idx_o, exp_item[IW], exp_item[IW-1:0]);
                    end
                end
                used_cnt[idx_o] = give_cnt[idx_o];
                n_closes++;
                idx_exp = (int'(idx_o) + 1) % L;
                idx_chk_pend = 1'b1;
            end
            if (fetch_vld_i && fetch_own_i) begin
                tx_cnt <= TX_LAT;
                tx_idx <= int'(idx_o);
                sb_q.push_back({err_mem[idx_o], idx_o});
            end else if (tx_cnt != 0) begin
                tx_cnt <= tx_cnt - 1;
                if (tx_cnt == 1) begin
                    if (err_mem[tx_idx]) tx_err_i <= 1'b1;
                    else                 tx_done_i <= 1'b1;
                end
            end
            if (fetch_req_o && !fetch_vld_i) begin
                fetch_vld_i <= 1'b1;
                fetch_own_i <= (give_cnt[idx_o] != used_cnt[idx_o]);
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        seq_checks++;
        if (!ok) begin
            seq_errs++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic pulse_poll();
        @(negedge clk) poll_i = 1'b1;
        @(negedge clk) poll_i = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk) begin clr_ais_i = 1'b1; clr_ti_i = 1'b1; end
        @(negedge clk) begin clr_ais_i = 1'b0; clr_ti_i = 1'b0; end
    endtask

    task automatic wait_ais();
        for (int i = 0; i < 300 && !ais_o; i++) @(negedge clk);
    endtask

    bit timed_out = 1'b0;

    initial begin
        for (int i = 0; i < L; i++) begin
            give_cnt[i] = 0;
            err_mem[i]  = 1'b0;
        end
        fork
            begin
                int base;
                bit seen;
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                chk(idx_o == 0,     "R1 reset index", int'(idx_o), 0);
                chk(!ais_o && !ti_o, "R1 reset flags", int'({ais_o, ti_o}), 0);
                chk(!fetch_req_o && !close_o, "R1 reset req/close", int'({fetch_req_o, close_o}), 0);

                // R10: start low, poll ignored
                pulse_poll();
                seen = 1'b0;
                for (int i = 0; i < 10; i++) begin
                    @(negedge clk);
                    if (fetch_req_o) seen = 1'b1;
                end
                chk(!seen, "R10 no fetch while start low", int'(seen), 0);

                // R2/R3/R6: full lap, then host-owned slot 0 after wrap
                for (int i = 0; i < L; i++) give_cnt[i]++;
                start_i = 1'b1;
                wait_ais();
                chk(n_closes == L, "R2 closes in one lap", n_closes, L);
                chk(ais_o && ti_o, "R3 flags after host-owned fetch", int'({ais_o, ti_o}), 3);
                chk(idx_o == 0,    "R6 R5 index held at wrap", int'(idx_o), 0);

                // R7: no automatic poll
                seen = 1'b0;
                for (int i = 0; i < 20; i++) begin
                    @(negedge clk);
                    if (fetch_req_o) seen = 1'b1;
                end
                chk(!seen, "R7 no fetch in suspension", int'(seen), 0);

                // R9: write-one-to-clear
                clear_flags();
                chk(!ais_o && !ti_o, "R9 flags cleared", int'({ais_o, ti_o}), 0);

                // R8 + R9 set wins: poll, slot still host-owned, clear ais in the set cycle
                base = n_closes;
                pulse_poll();
                while (!fetch_req_o) @(negedge clk);
                chk(idx_o == 0, "R8 refetch retained slot", int'(idx_o), 0);
                clr_ais_i = 1'b1;
                @(negedge clk) clr_ais_i = 1'b0;
                chk(ais_o, "R9 set wins over clear", int'(ais_o), 1);
                chk(ti_o,  "R8 flags set again", int'(ti_o), 1);
                chk(!fetch_req_o && n_closes == base, "R8 suspended again", n_closes, base);

                // R4/R5: abort on slot 1
                clear_flags();
                err_mem[1] = 1'b1;
                give_cnt[0]++;
                give_cnt[1]++;
                base = n_closes;
                pulse_poll();
                wait_ais();
                chk(n_closes == base + 2, "R4 closes before abort", n_closes, base + 2);
                chk(ais_o && ti_o, "R4 flags after abort", int'({ais_o, ti_o}), 3);
                chk(idx_o == 2,    "R5 index after abort", int'(idx_o), 2);
                repeat (5) @(negedge clk);
                chk(idx_o == 2 && !fetch_req_o, "R7 R5 hold after abort", int'(idx_o), 2);

                // R6: resume from mid-ring and wrap again
                err_mem[1] = 1'b0;
                clear_flags();
                give_cnt[2]++;
                give_cnt[3]++;
                base = n_closes;
                pulse_poll();
                wait_ais();
                chk(n_closes == base + 2, "R2 resume closes", n_closes, base + 2);
                chk(idx_o == 0, "R6 wrap after resume", int'(idx_o), 0);
                repeat (3) @(negedge clk);
                chk(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            seq_checks++;
            seq_errs++;
            $display("FAIL watchdog expired: actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", seq_checks + env_checks, seq_errs + env_errs);
        $finish;
    end

endmodule